// File: doc/BRIEF.md
# Reset, Watchdog and Power-Mode Controller

This block owns the chip-level reset and the low-power states of a small 8-bit controller. It accepts a reset on the external reset pin only after the pin has been high for a minimum number of oscillator periods. It runs a prescaled 8-bit watchdog that an external enable pin switches on. When the watchdog runs past its top value, the block drives a fixed-length reset pulse back out on the reset pin and resets its own state.

It also sequences two low-power modes. Idle stops the CPU clock but keeps the peripheral clock running. Idle ends on a pending enabled interrupt or on a reset. Power-down stops the oscillator, and only a reset ends it. The watchdog enable pin refuses entry into power-down. While either mode is active, the block forces the address-latch strobe, the program-fetch strobe and the PWM outputs to fixed levels.

The clock is the oscillator clock, so one cycle is one oscillator period. All inputs are taken as synchronous to that clock.

Top module: `rwp_ctrl`

## Requirements
- R1: After power-on reset is released, pm_mode is 0 (run), cpu_clk_en, periph_clk_en and osc_en are 1, and rst_pin_drive, sys_rst, pin_force, ale_lvl, psen_lvl and pwm_hi are 0.
- R2: sys_rst from the external pin rises only after rst_pin_in has been sampled high on RST_MIN (24) consecutive clock edges. A high run of 23 edges has no effect. sys_rst falls one edge after the pin is sampled low.
- R3: The watchdog advances only while wdt_en_pin is 1. It counts an 8-bit value up by one every PRESCALE (4) enabled cycles. Overflow happens on the tick that finds the count at 0xFF. With preset 0xFE loaded while disabled, overflow occurs on the 8th edge after enable rises.
- R4: A wdt_reload strobe loads wdt_preset and restarts the prescaler. From preset 0xF0, overflow occurs 64 edges after the reload edge. A reload on the overflow edge cancels that overflow.
- R5: On overflow, rst_pin_drive and sys_rst are high for exactly PULSE_LEN (24) cycles. This clears the watchdog and returns pm_mode to run, including from idle.
- R6: idle_req in run gives pm_mode 1 on the next edge, with cpu_clk_en 0 and periph_clk_en and osc_en still 1. pd_req is ignored while in idle.
- R7: Idle is left for run on the edge where irq_pending is 1, or by a qualified pin reset.
- R8: pd_req in run, with wdt_en_pin 0, gives pm_mode 2 with cpu_clk_en, periph_clk_en and osc_en all 0. irq_pending and idle_req are then ignored, and only a reset returns to run.
- R9: While wdt_en_pin is 1, pd_req is refused and the mode stays run. When both requests arrive together, power-down wins if it is allowed; otherwise idle is entered.
- R10: In idle, pin_force, ale_lvl, psen_lvl and pwm_hi are 1. In power-down, pin_force and pwm_hi are 1 and ale_lvl and psen_lvl are 0. In run all four are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| por_n | input | 1 | Asynchronous active-low power-on reset |
| rst_pin_in | input | 1 | Level sampled from the external reset pin |
| wdt_en_pin | input | 1 | Watchdog enable pin; also refuses power-down |
| idle_req | input | 1 | Request to enter idle |
| pd_req | input | 1 | Request to enter power-down |
| irq_pending | input | 1 | An enabled interrupt is pending |
| wdt_reload | input | 1 | Strobe loading the watchdog preset |
| wdt_preset | input | WDT_W | Value loaded on reload |
| rst_pin_drive | output | 1 | Drives the reset pin high during a watchdog pulse |
| sys_rst | output | 1 | Internal system reset |
| pm_mode | output | 2 | 0 run, 1 idle, 2 power-down |
| cpu_clk_en | output | 1 | CPU clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Oscillator enable |
| pin_force | output | 1 | Bus-control and PWM pins are overridden |
| ale_lvl | output | 1 | Forced address-latch strobe level |
| psen_lvl | output | 1 | Forced program-fetch strobe level |
| pwm_hi | output | 1 | PWM outputs held high |

## Verification
The assertions assume that every input is already synchronous to clk and changes only between rising edges. They also assume that rst_pin_in reflects the outside world alone, not the block's own drive. Under that assumption, a high sys_rst outside a watchdog pulse must be preceded by a long enough high run on the pin. The stimulus changes every input on the falling edge and never loops rst_pin_drive back into rst_pin_in. It also keeps wdt_en_pin low whenever a power-down entry is under test, so that the hold-in-power-down property describes a reachable state.

// File: rtl/rwp_pkg.sv
package rwp_pkg;
  typedef enum logic [1:0] {
    PM_RUN   = 2'd0,
    PM_IDLE  = 2'd1,
    PM_PDOWN = 2'd2
  } pm_state_e;
endpackage

// File: rtl/rwp_rst_sync.sv
module rwp_rst_sync (
  input  logic clk,
  input  logic por_n,
  output logic rst_n_s
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_s = sync_q[1];
endmodule

// File: rtl/rwp_rst_qual.sv
module rwp_rst_qual #(
  parameter int RST_MIN = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_hi,
  output logic ext_rst
);
  localparam int CW = $clog2(RST_MIN + 1);
  localparam logic [CW-1:0] TOP = CW'(RST_MIN);

  logic [CW-1:0] run_q;
  logic [CW-1:0] run_d;

  // length of the current high run, saturating at the qualification length
  always_comb begin
    run_d = run_q;
    if (!pin_hi)          run_d = '0;
    else if (run_q != TOP) run_d = run_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= run_d;
  end

  assign ext_rst = (run_q == TOP);
endmodule

// File: rtl/rwp_wdt.sv
module rwp_wdt #(
  parameter int PRESCALE = 4,
  parameter int WDT_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic             reload,
  input  logic [WDT_W-1:0] preset,
  output logic             ovf
);
  localparam int PRE_W = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [WDT_W-1:0] cnt_q, cnt_d;
  logic             tick;

  assign tick = run && (pre_q == PRE_LAST);
  // a reload in the same cycle refreshes instead of firing
  assign ovf  = tick && (&cnt_q) && !reload;

  always_comb begin
    pre_d = pre_q;
    cnt_d = cnt_q;
    if (clr) begin
      pre_d = '0;
      cnt_d = '0;
    end else if (reload) begin
      pre_d = '0;
      cnt_d = preset;
    end else if (run) begin
      pre_d = tick ? '0 : pre_q + PRE_W'(1);
      if (tick) cnt_d = cnt_q + WDT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else begin
      pre_q <= pre_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/rwp_pulse.sv
module rwp_pulse #(
  parameter int PULSE_LEN = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic active
);
  localparam int PW = $clog2(PULSE_LEN + 1);

  logic [PW-1:0] left_q, left_d;

  always_comb begin
    left_d = left_q;
    if (start)              left_d = PW'(PULSE_LEN);
    else if (left_q != '0)  left_d = left_q - PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) left_q <= '0;
    else        left_q <= left_d;
  end

  assign active = (left_q != '0);
endmodule

// File: rtl/rwp_pm_fsm.sv
module rwp_pm_fsm
  import rwp_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      clr,
  input  logic      idle_req,
  input  logic      pd_req,
  input  logic      pd_block,
  input  logic      wake,
  output pm_state_e state
);
  pm_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (clr) begin
      state_d = PM_RUN;
    end else begin
      unique case (state_q)
        PM_RUN: begin
          if (pd_req && !pd_block) state_d = PM_PDOWN;
          else if (idle_req)       state_d = PM_IDLE;
        end
        PM_IDLE:  if (wake) state_d = PM_RUN;
        PM_PDOWN: state_d = PM_PDOWN;
        default:  state_d = PM_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PM_RUN;
    else        state_q <= state_d;
  end

  assign state = state_q;
endmodule

// File: rtl/rwp_ctrl.sv
module rwp_ctrl
  import rwp_pkg::*;
#(
  parameter int RST_MIN   = 24,
  parameter int PULSE_LEN = 24,
  parameter int PRESCALE  = 4,
  parameter int WDT_W     = 8
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             rst_pin_in,
  input  logic             wdt_en_pin,
  input  logic             idle_req,
  input  logic             pd_req,
  input  logic             irq_pending,
  input  logic             wdt_reload,
  input  logic [WDT_W-1:0] wdt_preset,
  output logic             rst_pin_drive,
  output logic             sys_rst,
  output logic [1:0]       pm_mode,
  output logic             cpu_clk_en,
  output logic             periph_clk_en,
  output logic             osc_en,
  output logic             pin_force,
  output logic             ale_lvl,
  output logic             psen_lvl,
  output logic             pwm_hi
);
  logic      rst_n_s;
  logic      ext_rst;
  logic      wdt_ovf;
  logic      wdt_run;
  pm_state_e state;

  rwp_rst_sync u_sync (
    .clk     (clk),
    .por_n   (por_n),
    .rst_n_s (rst_n_s)
  );

  rwp_rst_qual #(.RST_MIN(RST_MIN)) u_qual (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .pin_hi  (rst_pin_in),
    .ext_rst (ext_rst)
  );

  // oscillator stopped in power-down freezes the watchdog too
  assign wdt_run = wdt_en_pin && (state != PM_PDOWN);

  rwp_wdt #(.PRESCALE(PRESCALE), .WDT_W(WDT_W)) u_wdt (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .clr    (sys_rst),
    .run    (wdt_run),
    .reload (wdt_reload),
    .preset (wdt_preset),
    .ovf    (wdt_ovf)
  );

  rwp_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .start  (wdt_ovf),
    .active (rst_pin_drive)
  );

  assign sys_rst = ext_rst || rst_pin_drive;

  rwp_pm_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .clr      (sys_rst),
    .idle_req (idle_req),
    .pd_req   (pd_req),
    .pd_block (wdt_en_pin),
    .wake     (irq_pending),
    .state    (state)
  );

  assign pm_mode       = state;
  assign cpu_clk_en    = (state == PM_RUN);
  assign periph_clk_en = (state != PM_PDOWN);
  assign osc_en        = (state != PM_PDOWN);
  assign pin_force     = (state != PM_RUN);
  assign ale_lvl       = (state == PM_IDLE);
  assign psen_lvl      = (state == PM_IDLE);
  assign pwm_hi        = (state != PM_RUN);
endmodule

// File: rtl/rwp_ctrl_chk.sv
module rwp_ctrl_chk #(
  parameter int RST_MIN   = 24,
  parameter int PULSE_LEN = 24
) (
  input logic       clk,
  input logic       rst_n,
  input logic       rst_pin_in,
  input logic       wdt_en_pin,
  input logic       pd_req,
  input logic       irq_pending,
  input logic       rst_pin_drive,
  input logic       sys_rst,
  input logic [1:0] pm_mode,
  input logic       ale_lvl,
  input logic       psen_lvl,
  input logic       pwm_hi,
  input logic       osc_en
);
  logic [15:0] hi_run;
  logic [15:0] drv_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_run  <= '0;
      drv_len <= '0;
    end else begin
      hi_run  <= !rst_pin_in ? 16'd0 : ((hi_run == 16'hFFFF) ? hi_run : hi_run + 16'd1);
      drv_len <= rst_pin_drive ? drv_len + 16'd1 : 16'd0;
    end
  end

  // R2
  ext_rst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_rst && !rst_pin_drive) |-> (hi_run >= 16'(RST_MIN)));

  // R5
  wd_pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_pin_drive && $past(rst_pin_drive)) |-> (drv_len == 16'(PULSE_LEN)));

  // R5
  wd_pulse_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pin_drive |-> sys_rst);

  // R7
  idle_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_mode == 2'd1 && irq_pending && !sys_rst) |=> (pm_mode == 2'd0));

  // R8
  pd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_mode == 2'd2 && !sys_rst) |=> (pm_mode == 2'd2));

  // R9
  pd_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_mode == 2'd0 && pd_req && wdt_en_pin) |=> (pm_mode != 2'd2));

  // R10
  idle_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_mode == 2'd1) |-> (ale_lvl && psen_lvl && pwm_hi));

  // R10
  pd_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_mode == 2'd2) |-> (!ale_lvl && !psen_lvl && pwm_hi && !osc_en));
endmodule

bind rwp_ctrl rwp_ctrl_chk #(.RST_MIN(RST_MIN), .PULSE_LEN(PULSE_LEN)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n_s),
  .rst_pin_in    (rst_pin_in),
  .wdt_en_pin    (wdt_en_pin),
  .pd_req        (pd_req),
  .irq_pending   (irq_pending),
  .rst_pin_drive (rst_pin_drive),
  .sys_rst       (sys_rst),
  .pm_mode       (pm_mode),
  .ale_lvl       (ale_lvl),
  .psen_lvl      (psen_lvl),
  .pwm_hi        (pwm_hi),
  .osc_en        (osc_en)
);

// File: tb/tb_rwp_ctrl.sv
module tb_rwp_ctrl;
  logic       clk = 1'b0;
  logic       por_n;
  logic       rst_pin_in, wdt_en_pin, idle_req, pd_req, irq_pending, wdt_reload;
  logic [7:0] wdt_preset;
  logic       rst_pin_drive, sys_rst, cpu_clk_en, periph_clk_en, osc_en;
  logic       pin_force, ale_lvl, psen_lvl, pwm_hi;
  logic [1:0] pm_mode;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  rwp_ctrl dut (
    .clk(clk), .por_n(por_n), .rst_pin_in(rst_pin_in), .wdt_en_pin(wdt_en_pin),
    .idle_req(idle_req), .pd_req(pd_req), .irq_pending(irq_pending),
    .wdt_reload(wdt_reload), .wdt_preset(wdt_preset),
    .rst_pin_drive(rst_pin_drive), .sys_rst(sys_rst), .pm_mode(pm_mode),
    .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en), .osc_en(osc_en),
    .pin_force(pin_force), .ale_lvl(ale_lvl), .psen_lvl(psen_lvl), .pwm_hi(pwm_hi)
  );

  // {idle,pd,en,irq, mode[1:0], force,ale,psen,pwm,cpu,osc}
  localparam logic [11:0] VEC [10] = '{
    12'b0000_00_000011,  // R1 run baseline
    12'b1000_01_111101,  // R6 R10 enter idle
    12'b0100_01_111101,  // R6 pd ignored in idle
    12'b0001_00_000011,  // R7 wake on irq
    12'b0110_00_000011,  // R9 pd refused while enable high
    12'b1110_01_111101,  // R9 both, blocked -> idle
    12'b0011_00_000011,  // R7 wake
    12'b1100_10_100100,  // R9 R8 R10 both, allowed -> power-down
    12'b0001_10_100100,  // R8 irq ignored
    12'b1000_10_100100   // R8 idle ignored
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog run did not finish actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    int w;
    int bad;
    por_n = 1'b0; rst_pin_in = 1'b0; wdt_en_pin = 1'b0; idle_req = 1'b0;
    pd_req = 1'b0; irq_pending = 1'b0; wdt_reload = 1'b0; wdt_preset = 8'h00;
    repeat (3) tick();
    por_n = 1'b1;
    repeat (3) tick();

    // R1 reset state
    check("R1 mode", pm_mode, 2'd0);
    check("R1 clocks", {cpu_clk_en, periph_clk_en, osc_en}, 3'b111);
    check("R1 resets", {rst_pin_drive, sys_rst}, 2'b00);
    check("R1 pins", {pin_force, ale_lvl, psen_lvl, pwm_hi}, 4'b0000);

    // mode table R6 R7 R8 R9 R10
    for (int i = 0; i < 10; i++) begin
      {idle_req, pd_req, wdt_en_pin, irq_pending} = VEC[i][11:8];
      tick();
      check($sformatf("R6-row%0d mode", i), pm_mode, VEC[i][7:6]);
      check($sformatf("R10-row%0d pins", i), {pin_force, ale_lvl, psen_lvl, pwm_hi}, VEC[i][5:2]);
      check($sformatf("R8-row%0d clocks", i), {cpu_clk_en, osc_en, periph_clk_en}, {VEC[i][1:0], VEC[i][0]});
    end
    {idle_req, pd_req, wdt_en_pin, irq_pending} = 4'b0000;
    tick();

    // R2 short high run from power-down: no reset
    rst_pin_in = 1'b1;
    bad = 0;
    for (int i = 0; i < 23; i++) begin
      tick();
      if (sys_rst) bad++;
    end
    rst_pin_in = 1'b0;
    tick();
    check("R2 23-edge run ignored", bad, 0);
    check("R8 still power-down", pm_mode, 2'd2);

    // R2 R8 qualified reset exits power-down
    rst_pin_in = 1'b1;
    repeat (23) tick();
    check("R2 not yet at 23", sys_rst, 1'b0);
    tick();
    check("R2 asserted at 24", sys_rst, 1'b1);
    tick();
    check("R8 reset exits power-down", pm_mode, 2'd0);
    check("R8 oscillator back", osc_en, 1'b1);
    rst_pin_in = 1'b0;
    tick();
    check("R2 release", sys_rst, 1'b0);

    // R7 idle exit by reset
    idle_req = 1'b1;
    tick();
    idle_req = 1'b0;
    check("R7 in idle", pm_mode, 2'd1);
    rst_pin_in = 1'b1;
    repeat (25) tick();
    rst_pin_in = 1'b0;
    tick();
    check("R7 reset exits idle", pm_mode, 2'd0);

    // R3 disabled watchdog does not count
    wdt_preset = 8'hFE; wdt_reload = 1'b1;
    tick();
    wdt_reload = 1'b0;
    bad = 0;
    for (int i = 0; i < 100; i++) begin
      tick();
      if (rst_pin_drive) bad++;
    end
    check("R3 idle counter while disabled", bad, 0);
    wdt_en_pin = 1'b1;
    n = 0;
    while (!rst_pin_drive && n < 40) begin
      tick();
      n++;
    end
    check("R3 overflow edge after enable", n, 8);

    // R5 pulse length and internal reset
    w = 0; bad = 0;
    while (rst_pin_drive && w < 100) begin
      if (!sys_rst) bad++;
      w++;
      if (w == 1) wdt_en_pin = 1'b0;
      tick();
    end
    check("R5 pulse length", w, 24);
    check("R5 sys_rst during pulse", bad, 0);

    // R4 reload preset timing
    wdt_en_pin = 1'b1; wdt_preset = 8'hF0; wdt_reload = 1'b1;
    tick();
    wdt_reload = 1'b0;
    n = 0;
    while (!rst_pin_drive && n < 200) begin
      tick();
      n++;
    end
    check("R4 overflow 64 edges after reload", n, 64);
    wdt_en_pin = 1'b0;
    while (rst_pin_drive) tick();

    // R4 periodic refresh keeps the watchdog quiet
    wdt_en_pin = 1'b1;
    bad = 0;
    for (int k = 0; k < 8; k++) begin
      wdt_reload = 1'b1;
      tick();
      wdt_reload = 1'b0;
      for (int i = 0; i < 40; i++) begin
        tick();
        if (rst_pin_drive) bad++;
      end
    end
    check("R4 refresh prevents overflow", bad, 0);

    // R4 reload on the overflow edge cancels it
    wdt_reload = 1'b1;
    tick();
    wdt_reload = 1'b0;
    repeat (63) tick();
    check("R4 no pulse before overflow edge", rst_pin_drive, 1'b0);
    wdt_reload = 1'b1;
    tick();
    wdt_reload = 1'b0;
    bad = 0;
    for (int i = 0; i < 10; i++) begin
      if (rst_pin_drive) bad++;
      tick();
    end
    check("R4 reload cancels overflow", bad, 0);
    wdt_en_pin = 1'b0;
    tick();

    // R5 overflow during idle returns to run
    wdt_en_pin = 1'b1; wdt_preset = 8'hFE; wdt_reload = 1'b1;
    tick();
    wdt_reload = 1'b0; idle_req = 1'b1;
    tick();
    idle_req = 1'b0;
    check("R5 idle before overflow", pm_mode, 2'd1);
    n = 0;
    while (!rst_pin_drive && n < 40) begin
      tick();
      n++;
    end
    check("R5 watchdog runs in idle", rst_pin_drive, 1'b1);
    wdt_en_pin = 1'b0;
    while (rst_pin_drive) tick();
    check("R5 mode after pulse", pm_mode, 2'd0);
    check("R5 cpu clock after pulse", cpu_clk_en, 1'b1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule